// File: doc/BRIEF.md
# Quaternary Line Frame Generator

This block produces the transmit symbol stream of a 160 kbit/s digital subscriber loop transceiver. A serial payload bit stream enters through a ready/valid handshake. The block cuts the stream into frames of 120 quaternary symbols. The first 9 symbols of each frame carry a fixed sync word, and the remaining 111 symbols carry 222 payload bits.

The payload bits pass through a self-synchronising scrambler of order 23. They are then paired, and each pair is emitted as one four-level symbol. Eight frames form a superframe. The first frame of each superframe sends its sync word with every symbol sign-inverted, so the receiver can find the superframe boundary.

A symbol-rate enable paces the output, one symbol per enable, nominally at 80 k symbols/s. Each emitted symbol is flagged by a one-cycle valid pulse. The first symbol of each frame and of each superframe is also marked. The surrounding logic multiplexes the channel bits ahead of this block and drives the line after it.

Top module: `qtx_framer`

## Requirements
- R1: A frame is 120 symbols. `frame_start_o` is high together with `sym_valid_o` on symbol 0 of every frame and at no other time.
- R2: Symbols 0..8 of each frame are the sync word +3 +3 −3 −3 −3 +3 −3 +3 +3, in that order. No payload bit is consumed for these symbols.
- R3: Frame 0 of each 8-frame superframe sends the sync word with every sign inverted. `sframe_start_o` is high on symbol 0 of that frame only.
- R4: Each payload bit is scrambled as out = in XOR s5 XOR s23. Here s_k is the scrambled bit sent k bits earlier. The scrambler history is all zeros after reset, and the first bit of a pair is scrambled before the second.
- R5: The scrambler history does not advance during sync symbols. Scrambling resumes after the sync word from the state left by the previous frame.
- R6: The symbol code on `sym_code_o` is {first bit, second bit} of the scrambled pair. Bit 1 is the sign (1 = positive) and bit 0 is the magnitude (0 = level 3, 1 = level 1). So 10 = +3, 11 = +1, 01 = −1 and 00 = −3; there is no zero level.
- R7: Payload bits are taken in arrival order. The first bit accepted for a symbol becomes its first (sign) bit.
- R8: A data symbol is emitted only once two payload bits are buffered. Otherwise the enable has no effect and no symbol, marker or counter step results.
- R9: `pl_ready_o` is low while two payload bits are buffered and not yet consumed. Valid data offered then is not taken.
- R10: After reset all outputs are low except `pl_ready_o`, which is high. An accepted enable produces `sym_valid_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_en_i | input | 1 | Symbol-rate enable |
| pl_data_i | input | 1 | Serial payload bit |
| pl_valid_i | input | 1 | Payload bit valid |
| pl_ready_o | output | 1 | Payload bit accepted when high with valid |
| sym_valid_o | output | 1 | Symbol emitted this cycle |
| sym_code_o | output | 2 | Symbol code {sign, magnitude} |
| frame_start_o | output | 1 | Symbol 0 of a frame |
| sframe_start_o | output | 1 | Symbol 0 of a superframe |

## Verification
A wrong scrambler history shows at once: a single flipped history bit corrupts a data symbol within 23 payload bits, and every later data symbol keeps repeating the damage. A wrong symbol or frame counter shows within one frame: the sync word appears in the wrong place, or `frame_start_o` arrives off the 120-symbol grid. A wrong superframe counter shows within eight frames, as a missing or extra inverted sync word. A lost or duplicated payload bit shifts every following symbol, so the scoreboard reports it at the next data symbol.

// File: rtl/qtx_pkg.sv
package qtx_pkg;
  typedef logic [1:0] quat_t;  // {sign, mag}: 10=+3 11=+1 01=-1 00=-3
  localparam int unsigned QTX_FRAME_SYMS = 120;
  localparam int unsigned QTX_SYNC_SYMS  = 9;
  localparam int unsigned QTX_SF_FRAMES  = 8;
  localparam int unsigned QTX_SCR_ORDER  = 23;
  localparam int unsigned QTX_SCR_TAP    = 5;
endpackage

// File: rtl/qtx_pair_buf.sv
module qtx_pair_buf (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       valid_i,
  output logic       ready_o,
  input  logic       take_i,
  output logic [1:0] pair_o,
  output logic       full_o
);
  logic [1:0] cnt_q;
  logic [1:0] pair_q;

  assign ready_o = (cnt_q != 2'd2);
  assign full_o  = (cnt_q == 2'd2);
  assign pair_o  = pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pair_q <= '0;
    end else if (take_i) begin
      cnt_q <= '0;
    end else if (valid_i && ready_o) begin
      if (cnt_q == 2'd0) pair_q[1] <= bit_i;
      else               pair_q[0] <= bit_i;
      cnt_q <= cnt_q + 2'd1;
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 2'd2);
  a_r8_take_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_o);
  a_r9_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !take_i) |=> full_o && $stable(pair_o));
endmodule

// File: rtl/qtx_scrambler.sv
module qtx_scrambler #(
  parameter int unsigned ORDER = qtx_pkg::QTX_SCR_ORDER,
  parameter int unsigned TAP   = qtx_pkg::QTX_SCR_TAP
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [1:0] d_i,
  output logic [1:0] q_o
);
  logic [ORDER:1] hist_q;
  logic b_first, b_second;

  // two serial steps per symbol, first bit feeds the second
  assign b_first  = d_i[1] ^ hist_q[TAP]   ^ hist_q[ORDER];
  assign b_second = d_i[0] ^ hist_q[TAP-1] ^ hist_q[ORDER-1];
  assign q_o = {b_first, b_second};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= '0;
    else if (step_i) hist_q <= {hist_q[ORDER-2:1], b_first, b_second};
  end

  a_r5_hold_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(hist_q));
endmodule

// File: rtl/qtx_seq.sv
module qtx_seq #(
  parameter int unsigned FRAME_SYMS = qtx_pkg::QTX_FRAME_SYMS,
  parameter int unsigned SYNC_SYMS  = qtx_pkg::QTX_SYNC_SYMS,
  parameter int unsigned SF_FRAMES  = qtx_pkg::QTX_SF_FRAMES,
  localparam int unsigned SW = $clog2(FRAME_SYMS),
  localparam int unsigned FW = (SF_FRAMES > 1) ? $clog2(SF_FRAMES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [SW-1:0] sym_o,
  output logic          in_sync_o,
  output logic          frame_first_o,
  output logic          sf_first_o
);
  logic [SW-1:0] sym_q;
  logic [FW-1:0] frm_q;
  logic          last_sym;

  assign last_sym      = (sym_q == SW'(FRAME_SYMS - 1));
  assign sym_o         = sym_q;
  assign in_sync_o     = (sym_q < SW'(SYNC_SYMS));
  assign frame_first_o = (sym_q == '0);
  assign sf_first_o    = (frm_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q <= '0;
      frm_q <= '0;
    end else if (adv_i) begin
      sym_q <= last_sym ? '0 : sym_q + SW'(1);
      if (last_sym)
        frm_q <= (frm_q == FW'(SF_FRAMES - 1)) ? '0 : frm_q + FW'(1);
    end
  end

  a_r1_sym_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_q < SW'(FRAME_SYMS));
  a_r3_frm_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_q <= FW'(SF_FRAMES - 1));
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(sym_q) && $stable(frm_q));
endmodule

// File: rtl/qtx_framer.sv
module qtx_framer #(
  parameter int unsigned FRAME_SYMS = qtx_pkg::QTX_FRAME_SYMS,
  parameter int unsigned SYNC_SYMS  = qtx_pkg::QTX_SYNC_SYMS,
  parameter int unsigned SF_FRAMES  = qtx_pkg::QTX_SF_FRAMES,
  parameter int unsigned SCR_ORDER  = qtx_pkg::QTX_SCR_ORDER,
  parameter int unsigned SCR_TAP    = qtx_pkg::QTX_SCR_TAP,
  // bit k = sign of sync symbol k (1 = +3)
  parameter logic [SYNC_SYMS-1:0] SYNC_SIGN = 9'b110100011,
  localparam int unsigned SW = $clog2(FRAME_SYMS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_en_i,
  input  logic       pl_data_i,
  input  logic       pl_valid_i,
  output logic       pl_ready_o,
  output logic       sym_valid_o,
  output logic [1:0] sym_code_o,
  output logic       frame_start_o,
  output logic       sframe_start_o
);
  import qtx_pkg::*;

  logic          full, take, adv;
  logic [1:0]    pair, scr_pair;
  logic [SW-1:0] sym;
  logic          in_sync, frame_first, sf_first;
  logic          sync_sign;
  quat_t         code_d;

  qtx_pair_buf u_buf (
    .clk_i, .rst_ni,
    .bit_i(pl_data_i), .valid_i(pl_valid_i), .ready_o(pl_ready_o),
    .take_i(take), .pair_o(pair), .full_o(full)
  );

  qtx_seq #(.FRAME_SYMS(FRAME_SYMS), .SYNC_SYMS(SYNC_SYMS), .SF_FRAMES(SF_FRAMES)) u_seq (
    .clk_i, .rst_ni, .adv_i(adv),
    .sym_o(sym), .in_sync_o(in_sync), .frame_first_o(frame_first), .sf_first_o(sf_first)
  );

  qtx_scrambler #(.ORDER(SCR_ORDER), .TAP(SCR_TAP)) u_scr (
    .clk_i, .rst_ni, .step_i(take), .d_i(pair), .q_o(scr_pair)
  );

  assign adv  = sym_en_i && (in_sync || full);
  assign take = adv && !in_sync;

  always_comb begin
    sync_sign = 1'b0;
    for (int i = 0; i < int'(SYNC_SYMS); i++)
      if (sym == SW'(i)) sync_sign = SYNC_SIGN[i];
  end

  // superframe marks: sign inversion of every sync symbol, outer level kept
  assign code_d = in_sync ? quat_t'({sync_sign ^ sf_first, 1'b0}) : quat_t'(scr_pair);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_valid_o    <= 1'b0;
      sym_code_o     <= '0;
      frame_start_o  <= 1'b0;
      sframe_start_o <= 1'b0;
    end else begin
      sym_valid_o    <= adv;
      frame_start_o  <= adv && frame_first;
      sframe_start_o <= adv && frame_first && sf_first;
      if (adv) sym_code_o <= code_d;
    end
  end

  a_r1_fs_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> sym_valid_o);
  a_r3_sf_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sframe_start_o |-> frame_start_o);
  a_r10_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> sym_valid_o);
  a_r8_no_enable_no_symbol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_en_i |=> !sym_valid_o);
  a_r2_sync_no_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sync && full) |=> full);
endmodule

// File: tb/qtx_framer_test.sv
module qtx_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_en = 1'b0, pl_data = 1'b0, pl_valid = 1'b0;
  logic pl_ready, sym_valid, fs, sfs;
  logic [1:0] code;

  int total = 0, bad = 0;
  bit payload_q[$];
  int en_mode = 0;     // 0 every cycle, 1 every 3rd, 2 random
  int valid_pct = 100;
  bit done = 0;

  // model state
  int m_sym = 0, m_frm = 0, n_syms = 0;
  logic [23:1] m_hist = '0;
  localparam logic [8:0] SYNC = 9'b110100011;

  always #10 clk = ~clk;

  qtx_framer uut (
    .clk_i(clk), .rst_ni(rst_n), .sym_en_i(sym_en), .pl_data_i(pl_data),
    .pl_valid_i(pl_valid), .pl_ready_o(pl_ready), .sym_valid_o(sym_valid),
    .sym_code_o(code), .frame_start_o(fs), .sframe_start_o(sfs)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (sym %0d frame %0d)", req, act, exp, m_sym, m_frm);
    end
  endtask

  function automatic bit scr_bit(input bit d);
    bit o;
    o = d ^ m_hist[5] ^ m_hist[23];
    m_hist = {m_hist[22:1], o};
    return o;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && sym_valid) begin
      logic [1:0] exp;
      n_syms++;
      if (m_sym < 9) begin
        exp = {SYNC[m_sym] ^ (m_frm == 0), 1'b0};
        check(m_frm == 0 ? "R3 inverted sync" : "R2 sync word", 8'(code), 8'(exp));
      end else if (payload_q.size() < 2) begin
        check("R8 symbol without payload", 8'(payload_q.size()), 8'd2);
      end else begin
        bit a, b;
        a = payload_q.pop_front();
        b = payload_q.pop_front();
        exp[1] = scr_bit(a);
        exp[0] = scr_bit(b);
        check("R4 R6 R7 scrambled data", 8'(code), 8'(exp));
      end
      check("R1 frame_start", 8'(fs), 8'(m_sym == 0));
      check("R3 superframe start", 8'(sfs), 8'(m_sym == 0 && m_frm == 0));
      if (m_sym == 119) begin
        m_sym = 0;
        m_frm = (m_frm + 1) % 8;
      end else m_sym++;
    end
  end

  // driver: inputs change at negedge, acceptance read just after
  task automatic drive_cycle(input int idx);
    @(negedge clk);
    case (en_mode)
      0: sym_en = 1'b1;
      1: sym_en = (idx % 3 == 0);
      default: sym_en = ($urandom_range(0, 1) == 1);
    endcase
    pl_valid = ($urandom_range(1, 100) <= valid_pct);
    pl_data  = 1'($urandom_range(0, 1));
    #1;
    if (pl_valid && pl_ready) payload_q.push_back(pl_data);
  endtask

  initial begin
    #1;
    check("R10 reset valid", 8'(sym_valid), 8'd0);
    check("R10 reset ready", 8'(pl_ready), 8'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset code", 8'(code), 8'd0);
    check("R10 reset markers", 8'({fs, sfs}), 8'd0);

    // R9: fill the buffer with enable low, ready must drop, third bit not taken
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sym_en = 1'b0; pl_valid = 1'b1; pl_data = 1'(i == 0);
      #1;
      if (pl_valid && pl_ready) payload_q.push_back(pl_data);
    end
    check("R9 ready low when two buffered", 8'(pl_ready), 8'd0);
    check("R9 only two bits accepted", 8'(payload_q.size()), 8'd2);
    @(negedge clk);
    check("R8 no symbol without enable", 8'(sym_valid), 8'd0);

    en_mode = 0; valid_pct = 100;
    for (int i = 0; i < 1200; i++) drive_cycle(i);
    en_mode = 1; valid_pct = 70;
    for (int i = 0; i < 2400; i++) drive_cycle(i);

    // R8: stall payload with enable held high
    en_mode = 0; valid_pct = 0;
    for (int i = 0; i < 12; i++) drive_cycle(i);
    for (int i = 0; i < 5; i++) begin
      drive_cycle(i);
      check("R8 stall without payload", 8'(sym_valid), 8'd0);
    end

    en_mode = 2; valid_pct = 60;
    for (int i = 0; i < 6000; i++) drive_cycle(i);
    @(negedge clk); sym_en = 1'b0; pl_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 R3 at least two superframes", 8'(n_syms >= 1920), 8'd1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule